// File: doc/BRIEF.md
# Key-Guarded System Control Register File

This block is a word-addressed register file that sits on a simple 32-bit register bus inside a small processor system. It holds a board identifier, an LED word, two configuration words, a volatile flag bank and a non-volatile flag bank, and a reset control word. Each flag bank has one address that sets bits and another that clears them. A handful of addresses return fixed identification constants. The other decoded addresses read as zero and do not store writes.

The reset control word is protected by a 16-bit key. Software first writes the key to the lock word. While the lock word holds the key, writes to reset control are stored. If such a write has the request bit set, a single-cycle reset request is issued to the system. The non-volatile flags have their own power-on reset input, so they survive both the ordinary reset and any reset the block requests. An access to an address outside the decoded map raises a one-cycle error pulse.

Reads are combinational. `bus_rdata` shows the addressed word during the cycle in which `bus_rd` is high and is zero otherwise. Writes take effect on the rising clock edge. A read and a write in the same cycle return the value held before the write. Both resets are synchronous and active low.

Top module: `sctl_regfile`

## Requirements
- R1: While `rst_n` and `por_n` are low, and afterwards until the first write, reads return these values: the `BOARD_ID` parameter at 0x000, 3 at 0x030 (volatile flags), and 0 at 0x008, 0x020, 0x028, 0x02C, 0x038 and 0x040. `bus_rdata` is 0 whenever `bus_rd` is low.
- R2: The LED word (0x008) and the configuration words (0x028, 0x02C) return the full 32-bit value last written. A write to 0x000 leaves the identifier unchanged.
- R3: A write to the lock word (0x020) with data exactly 0x0000A05F stores 0xA05F. Any other data stores only bits 14:0, so bit 15 reads zero. The lock word reads zero-extended to 32 bits.
- R4: A write to reset control (0x040) is stored only while the lock word equals 0xA05F. Otherwise the stored value does not change.
- R5: `reset_req` is high for exactly the one cycle after an accepted reset-control write whose bit 8 is 1. Back-to-back accepted writes give back-to-back pulses. No pulse follows a rejected write or a write with bit 8 clear.
- R6: The volatile flags read at 0x030. A write to 0x030 ORs the data into the flags, and a write to 0x034 clears each flag bit whose data bit is 1.
- R7: The non-volatile flags read at 0x038. They are set through 0x038 and cleared through 0x03C by the same rules as R6. They are cleared only by `por_n`, and they keep their value across `rst_n`.
- R8: Reads return 1 at 0x044, 0x1000 at 0x050, 0x02000000 at 0x084 and 0xFF000000 at 0x088. Writes to these addresses change nothing.
- R9: All other decoded offsets read zero: 0x004, 0x00C to 0x01C, 0x024, 0x034, 0x03C, 0x048 to 0x074 except 0x050, 0x080 to 0x09C except 0x084 and 0x088, and 0x0C0 to 0x0D0. An access to any other offset, or to an address with bits 1:0 nonzero, reads zero and raises `bad_access` for the one following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset for all state except the non-volatile flags |
| por_n | input | 1 | Synchronous active-low power-on reset for the non-volatile flags |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| reset_req | output | 1 | One-cycle system reset request |
| bad_access | output | 1 | One-cycle pulse after an access to an undecoded address |

## Verification
The bench builds the block with a non-trivial `BOARD_ID` of 0xC0DE1234, so that an identifier stuck at zero or at the reset value of another register is caught. The other parameters keep their defaults. The 12-bit address width places offsets far above the decoded map, such as 0xFFC, within reach. With misalignment checking enabled, unaligned addresses exercise the error pulse. The default 32-bit flag width lets bits 31 and 15 of both flag banks be set and cleared, and the default key and request bit 8 match the lock and reset-request cases the bench drives.

// File: rtl/sctl_pkg.sv
`timescale 1ns/1ps
package sctl_pkg;

   localparam int DW = 32;

   // word indices (byte offset / 4) whose position software depends on
   localparam int W_ID   = 0;
   localparam int W_LED  = 2;
   localparam int W_LOCK = 8;
   localparam int W_CFGA = 10;
   localparam int W_CFGB = 11;
   localparam int W_VSET = 12;
   localparam int W_VCLR = 13;
   localparam int W_NSET = 14;
   localparam int W_NCLR = 15;
   localparam int W_RCTL = 16;
   localparam int W_PCI  = 17;
   localparam int W_LCD  = 20;
   localparam int W_PID0 = 33;
   localparam int W_PID1 = 34;

   localparam logic [DW-1:0] C_PCI  = 32'h0000_0001;
   localparam logic [DW-1:0] C_LCD  = 32'h0000_1000;
   localparam logic [DW-1:0] C_PID0 = 32'h0200_0000;
   localparam logic [DW-1:0] C_PID1 = 32'hFF00_0000;

   typedef struct packed {
      logic known;
      logic id;
      logic led;
      logic lock;
      logic cfga;
      logic cfgb;
      logic vset;
      logic vclr;
      logic nset;
      logic nclr;
      logic rctl;
      logic pci;
      logic lcd;
      logic pid0;
      logic pid1;
   } sel_t;

   function automatic logic word_known(input logic [31:0] w);
      return (w <= 32'd29) || (w >= 32'd32 && w <= 32'd39) ||
             (w >= 32'd48 && w <= 32'd52);
   endfunction

endpackage

// File: rtl/sctl_decode.sv
`timescale 1ns/1ps
module sctl_decode
   import sctl_pkg::*;
#(
   parameter int ADDR_W          = 12,
   parameter bit ERR_ON_MISALIGN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_t              sel
);
   localparam int WI_W = ADDR_W - 2;

   logic [WI_W-1:0] widx;
   logic            align_ok;

   assign widx = addr[ADDR_W-1:2];

   generate
      if (ERR_ON_MISALIGN) begin : g_strict
         assign align_ok = (addr[1:0] == 2'b00);
      end else begin : g_loose
         logic [1:0] unused_lsb;
         assign unused_lsb = addr[1:0];
         assign align_ok   = 1'b1;
      end
   endgenerate

   always_comb begin
      sel = '0;
      if (align_ok) begin
         sel.known = word_known(32'(widx));
         sel.id    = (widx == WI_W'(W_ID));
         sel.led   = (widx == WI_W'(W_LED));
         sel.lock  = (widx == WI_W'(W_LOCK));
         sel.cfga  = (widx == WI_W'(W_CFGA));
         sel.cfgb  = (widx == WI_W'(W_CFGB));
         sel.vset  = (widx == WI_W'(W_VSET));
         sel.vclr  = (widx == WI_W'(W_VCLR));
         sel.nset  = (widx == WI_W'(W_NSET));
         sel.nclr  = (widx == WI_W'(W_NCLR));
         sel.rctl  = (widx == WI_W'(W_RCTL));
         sel.pci   = (widx == WI_W'(W_PCI));
         sel.lcd   = (widx == WI_W'(W_LCD));
         sel.pid0  = (widx == WI_W'(W_PID0));
         sel.pid1  = (widx == WI_W'(W_PID1));
      end
   end
endmodule

// File: rtl/sctl_lock_gate.sv
`timescale 1ns/1ps
module sctl_lock_gate #(
   parameter logic [15:0] KEY = 16'hA05F
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [15:0] lock_q,
   output logic        unlocked
);
   logic exact;

   assign exact    = (wdata == {16'h0000, KEY});
   assign unlocked = (lock_q == KEY);

   always_ff @(posedge clk) begin
      if (!rst_n)
         lock_q <= '0;
      else if (wr_en)
         lock_q <= exact ? KEY : {1'b0, wdata[14:0]};
   end

   AST_LOCK_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[15] |-> (lock_q == KEY)); // R3
   AST_LOCK_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && $past(wdata) == {16'h0000, KEY}) |-> unlocked); // R3
endmodule

// File: rtl/sctl_flag_bank.sv
`timescale 1ns/1ps
module sctl_flag_bank #(
   parameter int           W    = 32,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] data,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= INIT;
      else if (set_en)
         q <= q | data;
      else if (clr_en)
         q <= q & ~data;
   end

   AST_FLAG_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(set_en)) |-> ((q & $past(data)) == $past(data))); // R6
   AST_FLAG_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(clr_en) && !$past(set_en)) |-> ((q & $past(data)) == '0)); // R7
endmodule

// File: rtl/sctl_regfile.sv
`timescale 1ns/1ps
module sctl_regfile
   import sctl_pkg::*;
#(
   parameter int                ADDR_W          = 12,
   parameter logic [31:0]       BOARD_ID        = 32'h0000_0000,
   parameter int                FLAG_W          = 32,
   parameter logic [FLAG_W-1:0] VFLAG_INIT      = FLAG_W'(3),
   parameter logic [15:0]       LOCK_KEY        = 16'hA05F,
   parameter int                REQ_BIT         = 8,
   parameter bit                ERR_ON_MISALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              reset_req,
   output logic              bad_access
);
   localparam int NBANK = 2;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
         $error("sctl_regfile: ADDR_W must be within 8..32");
      end
      if (FLAG_W < 2 || FLAG_W > DW) begin : g_bad_flag_w
         $error("sctl_regfile: FLAG_W must be within 2..32");
      end
      if (REQ_BIT < 0 || REQ_BIT >= DW) begin : g_bad_req_bit
         $error("sctl_regfile: REQ_BIT out of range");
      end
   endgenerate

   sel_t        sel;
   logic [15:0] lock_q;
   logic        unlocked;
   logic [31:0] led_q, cfga_q, cfgb_q, rctl_q;
   logic        req_q, err_q;
   logic        rctl_take;

   logic [NBANK-1:0] bank_rst, bank_set, bank_clr;
   logic [FLAG_W-1:0] bank_q [NBANK];

   sctl_decode #(.ADDR_W(ADDR_W), .ERR_ON_MISALIGN(ERR_ON_MISALIGN)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   sctl_lock_gate #(.KEY(LOCK_KEY)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr && sel.lock),
      .wdata    (bus_wdata),
      .lock_q   (lock_q),
      .unlocked (unlocked)
   );

   // bank 0: volatile flags on rst_n; bank 1: non-volatile flags on por_n
   assign bank_rst = {por_n, rst_n};
   assign bank_set = {bus_wr && sel.nset, bus_wr && sel.vset};
   assign bank_clr = {bus_wr && sel.nclr, bus_wr && sel.vclr};

   generate
      for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
         localparam logic [FLAG_W-1:0] B_INIT = (gi == 0) ? VFLAG_INIT : '0;
         sctl_flag_bank #(.W(FLAG_W), .INIT(B_INIT)) u_bank (
            .clk    (clk),
            .rst_n  (bank_rst[gi]),
            .set_en (bank_set[gi]),
            .clr_en (bank_clr[gi]),
            .data   (bus_wdata[FLAG_W-1:0]),
            .q      (bank_q[gi])
         );
      end
   endgenerate

   assign rctl_take = bus_wr && sel.rctl && unlocked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         led_q  <= '0;
         cfga_q <= '0;
         cfgb_q <= '0;
         rctl_q <= '0;
         req_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (bus_wr && sel.led)  led_q  <= bus_wdata;
         if (bus_wr && sel.cfga) cfga_q <= bus_wdata;
         if (bus_wr && sel.cfgb) cfgb_q <= bus_wdata;
         if (rctl_take)          rctl_q <= bus_wdata;
         req_q <= rctl_take && bus_wdata[REQ_BIT];
         err_q <= (bus_wr || bus_rd) && !sel.known;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel.id)        bus_rdata = BOARD_ID;
         else if (sel.led)  bus_rdata = led_q;
         else if (sel.lock) bus_rdata = {16'h0000, lock_q};
         else if (sel.cfga) bus_rdata = cfga_q;
         else if (sel.cfgb) bus_rdata = cfgb_q;
         else if (sel.vset) bus_rdata = 32'(bank_q[0]);
         else if (sel.nset) bus_rdata = 32'(bank_q[1]);
         else if (sel.rctl) bus_rdata = rctl_q;
         else if (sel.pci)  bus_rdata = C_PCI;
         else if (sel.lcd)  bus_rdata = C_LCD;
         else if (sel.pid0) bus_rdata = C_PID0;
         else if (sel.pid1) bus_rdata = C_PID1;
      end
   end

   assign reset_req  = req_q;
   assign bad_access = err_q;

   AST_RCTL_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel.rctl && !unlocked) |=> $stable(rctl_q)); // R4
   AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> ($past(bus_wr) && $past(sel.rctl) && $past(unlocked) && $past(bus_wdata[REQ_BIT]))); // R5
   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> (($past(bus_wr) || $past(bus_rd)) && !$past(sel.known))); // R9
   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0)); // R1
endmodule

// File: tb/tb_sctl_regfile.sv
`timescale 1ns/1ps
module tb_sctl_regfile;
   localparam logic [31:0] ID = 32'hC0DE_1234;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0, por_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        reset_req, bad_access;

   sctl_regfile #(.BOARD_ID(ID)) dut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .reset_req(reset_req), .bad_access(bad_access)
   );

   always #4 clk = ~clk;

   int    errors = 0, checks = 0;
   bit    checking = 0, done = 0;
   string cur_req = "R1";

   // behavioural reference
   bit [31:0] m_led, m_cfga, m_cfgb, m_rctl, m_vf, m_nf;
   bit [15:0] m_lock;
   bit        e_req, e_err;

   function automatic bit known(input bit [11:0] a);
      if (a[1:0] != 2'b00) return 0;
      return (a <= 12'h074) || (a >= 12'h080 && a <= 12'h09C) ||
             (a >= 12'h0C0 && a <= 12'h0D0);
   endfunction

   function automatic bit [31:0] ref_read(input bit [11:0] a);
      case (a)
         12'h000: return ID;
         12'h008: return m_led;
         12'h020: return {16'h0, m_lock};
         12'h028: return m_cfga;
         12'h02C: return m_cfgb;
         12'h030: return m_vf;
         12'h038: return m_nf;
         12'h040: return m_rctl;
         12'h044: return 32'h1;
         12'h050: return 32'h1000;
         12'h084: return 32'h0200_0000;
         12'h088: return 32'hFF00_0000;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!por_n) m_nf <= 0;
      else if (bus_wr && bus_addr == 12'h038) m_nf <= m_nf | bus_wdata;
      else if (bus_wr && bus_addr == 12'h03C) m_nf <= m_nf & ~bus_wdata;
      if (!rst_n) begin
         m_led <= 0; m_cfga <= 0; m_cfgb <= 0; m_rctl <= 0; m_vf <= 3;
         m_lock <= 0; e_req <= 0; e_err <= 0;
      end else begin
         e_req <= 0;
         e_err <= (bus_wr || bus_rd) && !known(bus_addr);
         if (bus_wr) begin
            case (bus_addr)
               12'h008: m_led  <= bus_wdata;
               12'h028: m_cfga <= bus_wdata;
               12'h02C: m_cfgb <= bus_wdata;
               12'h030: m_vf   <= m_vf | bus_wdata;
               12'h034: m_vf   <= m_vf & ~bus_wdata;
               12'h020: m_lock <= (bus_wdata == 32'hA05F) ? 16'hA05F : {1'b0, bus_wdata[14:0]};
               12'h040: if (m_lock == 16'hA05F) begin
                           m_rctl <= bus_wdata;
                           e_req  <= bus_wdata[8];
                        end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h (addr=%h) t=%0t",
                  cur_req, what, act, exp, bus_addr, $time);
      end
   endtask

   // compare on every clock, half a period after the edge
   always @(negedge clk) begin
      if (checking && !done) begin
         chk("rdata", bus_rdata, bus_rd ? ref_read(bus_addr) : 32'h0);
         chk("reset_req", {31'h0, reset_req}, {31'h0, e_req});
         chk("bad_access", {31'h0, bad_access}, {31'h0, e_err});
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
   endtask

   task automatic rd(input logic [11:0] a);
      @(posedge clk); #1;
      bus_wr = 0; bus_rd = 1; bus_addr = a; bus_wdata = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         bus_wr = 0; bus_rd = 0;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1; rst_n = 1; por_n = 1;
      checking = 1;

      cur_req = "R1"; // reset state
      rd(12'h000); rd(12'h030); rd(12'h038); rd(12'h020); rd(12'h008);
      rd(12'h028); rd(12'h02C); rd(12'h040); idle(2);

      cur_req = "R2";
      wr(12'h008, 32'hDEAD_BEEF); wr(12'h028, 32'h1357_9BDF); wr(12'h02C, 32'h8000_0001);
      wr(12'h000, 32'hFFFF_FFFF);
      rd(12'h008); rd(12'h028); rd(12'h02C); rd(12'h000);
      wr(12'h008, 32'h0000_00A5); rd(12'h008); idle(1);

      cur_req = "R3";
      wr(12'h020, 32'h1234_FFFF); rd(12'h020);
      wr(12'h020, 32'h0001_A05F); rd(12'h020);
      wr(12'h020, 32'h0000_A05F); rd(12'h020); idle(1);

      cur_req = "R4";
      wr(12'h020, 32'h0); wr(12'h040, 32'h0000_0155); rd(12'h040);
      wr(12'h020, 32'h0000_A05F); wr(12'h040, 32'h0000_00AB); rd(12'h040); idle(1);

      cur_req = "R5";
      wr(12'h040, 32'h0000_0100); idle(2);
      wr(12'h040, 32'h0000_01FF); wr(12'h040, 32'h0000_0100); idle(2);
      wr(12'h040, 32'h0000_0022); idle(2);
      wr(12'h020, 32'h0000_2000); wr(12'h040, 32'h0000_0100); idle(2); rd(12'h040);

      cur_req = "R6";
      wr(12'h030, 32'h8000_00F0); rd(12'h030);
      wr(12'h034, 32'h0000_0011); rd(12'h030);
      wr(12'h034, 32'hFFFF_FFFF); rd(12'h030);
      wr(12'h030, 32'h0000_8000); rd(12'h030); idle(1);

      cur_req = "R7";
      wr(12'h038, 32'h8000_80A5); rd(12'h038);
      wr(12'h03C, 32'h0000_0005); rd(12'h038);
      @(posedge clk); #1; bus_wr = 0; bus_rd = 0; rst_n = 0;
      @(posedge clk); #1; rst_n = 1;
      rd(12'h038); rd(12'h030);
      @(posedge clk); #1; bus_rd = 0; por_n = 0;
      @(posedge clk); #1; por_n = 1;
      rd(12'h038); idle(1);

      cur_req = "R8";
      rd(12'h044); rd(12'h050); rd(12'h084); rd(12'h088);
      wr(12'h044, 32'h0); wr(12'h050, 32'h0); wr(12'h084, 32'h1); wr(12'h088, 32'h2);
      rd(12'h044); rd(12'h050); rd(12'h084); rd(12'h088); idle(1);

      cur_req = "R9";
      rd(12'h004); rd(12'h00C); rd(12'h024); rd(12'h034); rd(12'h03C); rd(12'h0C0);
      rd(12'h078); idle(1); rd(12'hFFC); rd(12'h101); rd(12'h0D4);
      wr(12'h0A0, 32'h1234_5678); idle(1);
      wr(12'h00A, 32'hFFFF_FFFF); rd(12'h008); idle(2);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule